// File: doc/BRIEF.md
# Serial Address and Mode Controller for a Field Memory

This block is the command front end of a sequential-access field memory. Software-free logic upstream presents a row word and a column-plus-mode word one bit at a time on two serial lines, framed by an address clock. A RAM-enable strobe marks each memory cycle. On the strobe's falling edge the controller captures both serial words. The command captured on one strobe is carried out on the following strobe.

A command is a one-cycle pulse on one of four lines: read into output latch A, read into output latch B, write from input latch C, or refresh. The pulse comes with a row and a column address for the array model. A refresh takes its row from an internal counter and does not use the shifted words. A command that addresses a row outside the array is dropped and shown on an error line. After reset, a fixed number of strobes must pass before any command is carried out.

All control inputs are taken as already synchronous to the system clock `clk`. Edges on the address clock and on the strobe are detected by sampling them.

Top module: `field_addr_ctrl`

## Requirements
- R1: Both serial words are 8 bits wide and arrive LSB first. One bit of each is taken on every rising edge of `addr_clk`, and the most recent 8 bits form the word.
- R2: A falling edge of `ram_en` captures both words. The captured command is carried out at the next falling edge of `ram_en`, not at the edge that captured it.
- R3: In the column word, bits [5:0] are the column address, bit 6 is M0 and bit 7 is M1.
- R4: {M1,M0} = 00 pulses `rd_a`, 01 pulses `rd_b`, 10 pulses `wr_c` and 11 pulses `rfsh`. For the three non-refresh modes, `cmd_row` and `cmd_col` carry the captured row and column.
- R5: On a refresh, the shifted row and column are ignored. `cmd_row` is the internal refresh row and `cmd_col` is 0.
- R6: The refresh row is 0 after reset. It advances by one after each refresh that is carried out and wraps from 211 to 0.
- R7: The first eight falling edges of `ram_en` after reset carry out nothing. The ninth edge carries out the command captured at the eighth.
- R8: A non-refresh command whose row is above 211 gives a one-cycle `row_err` pulse instead of a command pulse. It leaves `cmd_row`, `cmd_col` and the refresh row unchanged.
- R9: Each pulse lasts one `clk` cycle. At most one of `rd_a`, `rd_b`, `wr_c`, `rfsh` and `row_err` is high at a time. `cmd_row` and `cmd_col` hold between commands.
- R10: During and right after reset, all pulse outputs are low and `cmd_row` and `cmd_col` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_clk | input | 1 | Serial address clock, sampled; a bit is taken on each rising edge |
| row_sdi | input | 1 | Serial row word, LSB first |
| col_sdi | input | 1 | Serial column-plus-mode word, LSB first |
| ram_en | input | 1 | RAM-enable strobe, sampled; a falling edge captures the words and carries out the previous command |
| rd_a | output | 1 | Pulse: read array into latch A |
| rd_b | output | 1 | Pulse: read array into latch B |
| wr_c | output | 1 | Pulse: write latch C into array |
| rfsh | output | 1 | Pulse: refresh at the internal row |
| row_err | output | 1 | Pulse: a command with an out-of-range row was dropped |
| cmd_row | output | 8 | Row address of the last command carried out |
| cmd_col | output | 6 | Column address of the last command carried out |

## Verification
A serial bit is taken on the first `clk` edge that sees `addr_clk` high. A strobe fall is acted on at the first `clk` edge that sees `ram_en` low. The command pulses and addresses are registered, so they are valid in the cycle right after that edge and clear one cycle later. The bench drives every input on the falling edge of `clk`. It reads the outputs on the falling edge one cycle after lowering `ram_en`, and again one cycle later to confirm the pulse has ended. The expected pulse and addresses come from a bench model of the previously captured word, the warm-up strobe count and the refresh row.

// File: rtl/sacm_pkg.sv
// Package: shared mode encoding for the serial address and mode controller.
// Assumes the two mode bits sit above the column field as {M1,M0}.
package sacm_pkg;
    typedef enum logic [1:0] {
        MODE_RD_A    = 2'b00,
        MODE_RD_B    = 2'b01,
        MODE_WR_C    = 2'b10,
        MODE_REFRESH = 2'b11
    } sacm_mode_e;
endpackage

// File: rtl/sacm_shift.sv
// Serial-in word register. On each qualified shift it takes one bit and
// places it at the MSB, so the first bit sent ends up at the LSB.
// Assumes shift_en is a one-cycle pulse per serial bit.
module sacm_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic [W-1:0] word
);
    // Shift the word right, taking the new bit in at the top
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {ser_in, word[W-1:1]};
    end
endmodule

// File: rtl/sacm_strobe.sv
// Edge detector for the address clock and the RAM-enable strobe, plus a
// warm-up counter that allows execution only after WARMUP strobe falls.
// Assumes addr_clk and ram_en are already synchronous to clk.
module sacm_strobe #(
    parameter int WARMUP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic addr_clk,
    input  logic ram_en,
    output logic sclk_rise,
    output logic re_fall,
    output logic exec_go,
    output logic warm_done
);
    localparam int CW = $clog2(WARMUP + 1);

    logic          sclk_q;
    logic          re_q;
    logic [CW-1:0] warm_cnt;

    // Keep the previous sample of both strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            re_q   <= 1'b0;
        end else begin
            sclk_q <= addr_clk;
            re_q   <= ram_en;
        end
    end

    assign sclk_rise = addr_clk & ~sclk_q;
    assign re_fall   = ~ram_en & re_q;
    assign warm_done = (warm_cnt == CW'(WARMUP));
    assign exec_go   = re_fall & warm_done;

    // Count strobe falls until the warm-up period has passed
    always_ff @(posedge clk) begin
        if (!rst_n)                    warm_cnt <= '0;
        else if (re_fall && !warm_done) warm_cnt <= warm_cnt + 1'b1;
    end

    // R7
    warm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_cnt <= CW'(WARMUP));

    // R7
    warm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warm_done) |-> $past(re_fall));
endmodule

// File: rtl/sacm_issue.sv
// Command stage. A strobe fall captures the shifted words as the pending
// command. An execute pulse decodes the previously pending command into one
// command pulse with addresses, a refresh at the internal row, or an error
// pulse for an out-of-range row.
// Assumes exec_go is only ever high together with re_fall, and that
// ROWS <= 2**ROW_W.
module sacm_issue
    import sacm_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 6,
    parameter int ROWS  = 212
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               re_fall,
    input  logic               exec_go,
    input  logic [ROW_W-1:0]   row_word,
    input  logic [COL_W+1:0]   col_word,
    output logic               rd_a,
    output logic               rd_b,
    output logic               wr_c,
    output logic               rfsh,
    output logic               row_err,
    output logic [ROW_W-1:0]   cmd_row,
    output logic [COL_W-1:0]   cmd_col
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] pend_row;
    logic [COL_W-1:0] pend_col;
    sacm_mode_e       pend_mode;
    logic [ROW_W-1:0] ref_row;
    logic             is_ref;
    logic             bad_row;

    // Capture the shifted words as the pending command on each strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_row  <= '0;
            pend_col  <= '0;
            pend_mode <= MODE_RD_A;
        end else if (re_fall) begin
            pend_row  <= row_word;
            pend_col  <= col_word[COL_W-1:0];
            pend_mode <= sacm_mode_e'(col_word[COL_W+1:COL_W]);
        end
    end

    assign is_ref  = (pend_mode == MODE_REFRESH);
    assign bad_row = !is_ref && (pend_row > LAST_ROW);

    // Carry out the pending command and drive one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_a    <= 1'b0;
            rd_b    <= 1'b0;
            wr_c    <= 1'b0;
            rfsh    <= 1'b0;
            row_err <= 1'b0;
            cmd_row <= '0;
            cmd_col <= '0;
        end else begin
            rd_a    <= 1'b0;
            rd_b    <= 1'b0;
            wr_c    <= 1'b0;
            rfsh    <= 1'b0;
            row_err <= 1'b0;
            if (exec_go) begin
                if (is_ref) begin
                    rfsh    <= 1'b1;
                    cmd_row <= ref_row;
                    cmd_col <= '0;
                end else if (bad_row) begin
                    row_err <= 1'b1;
                end else begin
                    cmd_row <= pend_row;
                    cmd_col <= pend_col;
                    case (pend_mode)
                        MODE_RD_A: rd_a <= 1'b1;
                        MODE_RD_B: rd_b <= 1'b1;
                        default:   wr_c <= 1'b1;
                    endcase
                end
            end
        end
    end

    // Internal refresh row: advance after each refresh, wrap at the last row
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_row <= '0;
        else if (exec_go && is_ref)
            ref_row <= (ref_row == LAST_ROW) ? '0 : ref_row + 1'b1;
    end

    // R9
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_a, rd_b, wr_c, rfsh, row_err}));

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a || rd_b || wr_c || rfsh || row_err) |=>
        !(rd_a || rd_b || wr_c || rfsh || row_err));

    // R8
    row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a || rd_b || wr_c) |-> (cmd_row <= LAST_ROW));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_err |-> ($stable(cmd_row) && $stable(cmd_col)));

    // R5
    ref_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh |-> (cmd_col == '0));

    // R6
    ref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh |-> (ref_row == ((cmd_row == LAST_ROW) ? '0 : cmd_row + 1'b1)));
endmodule

// File: rtl/field_addr_ctrl.sv
// Top of the serial address and mode controller. Two serial shifters
// collect the row and column-plus-mode words. The strobe unit finds the
// address clock rises and the RAM-enable falls and gates execution until
// warm-up ends. The issue stage decodes and emits commands.
// Assumes all inputs are synchronous to clk.
module field_addr_ctrl #(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 6,
    parameter int ROWS   = 212,
    parameter int WARMUP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_clk,
    input  logic             row_sdi,
    input  logic             col_sdi,
    input  logic             ram_en,
    output logic             rd_a,
    output logic             rd_b,
    output logic             wr_c,
    output logic             rfsh,
    output logic             row_err,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col
);
    localparam int CWORD_W = COL_W + 2;

    logic               sclk_rise;
    logic               re_fall;
    logic               exec_go;
    logic               warm_done;
    logic [ROW_W-1:0]   row_word;
    logic [CWORD_W-1:0] col_word;

    sacm_strobe #(.WARMUP(WARMUP)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_clk  (addr_clk),
        .ram_en    (ram_en),
        .sclk_rise (sclk_rise),
        .re_fall   (re_fall),
        .exec_go   (exec_go),
        .warm_done (warm_done)
    );

    sacm_shift #(.W(ROW_W)) u_row_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .ser_in   (row_sdi),
        .word     (row_word)
    );

    sacm_shift #(.W(CWORD_W)) u_col_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .ser_in   (col_sdi),
        .word     (col_word)
    );

    sacm_issue #(.ROW_W(ROW_W), .COL_W(COL_W), .ROWS(ROWS)) u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .re_fall  (re_fall),
        .exec_go  (exec_go),
        .row_word (row_word),
        .col_word (col_word),
        .rd_a     (rd_a),
        .rd_b     (rd_b),
        .wr_c     (wr_c),
        .rfsh     (rfsh),
        .row_err  (row_err),
        .cmd_row  (cmd_row),
        .cmd_col  (cmd_col)
    );

    // R7
    no_early_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a || rd_b || wr_c || rfsh || row_err) |-> $past(warm_done));

    // R2
    cmd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a || rd_b || wr_c || rfsh || row_err) |-> $past(re_fall));
endmodule

// File: tb/field_addr_ctrl_tb.sv
module field_addr_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_clk = 1'b0;
    logic       row_sdi = 1'b0;
    logic       col_sdi = 1'b0;
    logic       ram_en = 1'b1;
    logic       rd_a, rd_b, wr_c, rfsh, row_err;
    logic [7:0] cmd_row;
    logic [5:0] cmd_col;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model state
    int         falls   = 0;
    bit [7:0]   m_row   = 0;
    bit [7:0]   m_cword = 0;
    int         m_ref   = 0;
    bit [7:0]   last_row = 0;
    bit [5:0]   last_col = 0;

    field_addr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .addr_clk(addr_clk), .row_sdi(row_sdi),
        .col_sdi(col_sdi), .ram_en(ram_en), .rd_a(rd_a), .rd_b(rd_b),
        .wr_c(wr_c), .rfsh(rfsh), .row_err(row_err), .cmd_row(cmd_row),
        .cmd_col(cmd_col)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pulse vector {rd_a,rd_b,wr_c,rfsh,row_err} expected for a pending word
    function automatic bit [4:0] exp_pulses(input bit exec, input bit [7:0] row, input bit [7:0] cw);
        bit [1:0] mode = cw[7:6];
        if (!exec) return 5'b0;
        if (mode == 2'b11) return 5'b00010;
        if (row > 8'd211) return 5'b00001;
        case (mode)
            2'b00:   return 5'b10000;
            2'b01:   return 5'b01000;
            default: return 5'b00100;
        endcase
    endfunction

    task automatic shift_words(input bit [7:0] row, input bit [7:0] cw);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            row_sdi  = row[i];
            col_sdi  = cw[i];
            addr_clk = 1'b1;
            @(negedge clk);
            addr_clk = 1'b0;
        end
    endtask

    // one RE cycle: shift new words, strobe, check the previous command
    task automatic re_cycle(input bit [7:0] row, input bit [7:0] cw, input bit do_shift);
        bit       exec;
        bit [4:0] ep;
        bit [4:0] got;
        bit [7:0] erow;
        bit [5:0] ecol;
        if (do_shift) shift_words(row, cw);
        exec = (falls >= 8);
        ep   = exp_pulses(exec, m_row, m_cword);
        erow = last_row;
        ecol = last_col;
        if (ep[1]) begin
            erow = 8'(m_ref);
            ecol = 6'd0;
        end else if (ep[4] | ep[3] | ep[2]) begin
            erow = m_row;
            ecol = m_cword[5:0];
        end
        @(negedge clk);
        ram_en = 1'b0;
        @(negedge clk);
        got = {rd_a, rd_b, wr_c, rfsh, row_err};
        if (!exec)
            check(got == 5'b0, "R7 warm-up pulse", int'(got), 0);
        else if (ep[0])
            check(got == ep, "R8 error pulse", int'(got), int'(ep));
        else if (ep[1])
            check(got == ep, "R5 refresh pulse", int'(got), int'(ep));
        else
            check(got == ep, "R4 R2 decode pulse", int'(got), int'(ep));
        if (ep[1])
            check(cmd_row == erow, "R6 refresh row", int'(cmd_row), int'(erow));
        else if (ep[0])
            check(cmd_row == erow, "R8 row held", int'(cmd_row), int'(erow));
        else
            check(cmd_row == erow, "R1 R2 cmd_row", int'(cmd_row), int'(erow));
        check(cmd_col == ecol, "R3 cmd_col", int'(cmd_col), int'(ecol));
        ram_en = 1'b1;
        @(negedge clk);
        got = {rd_a, rd_b, wr_c, rfsh, row_err};
        check(got == 5'b0, "R9 pulse width", int'(got), 0);
        check(cmd_row == erow, "R9 cmd_row hold", int'(cmd_row), int'(erow));
        // model update
        if (ep[1]) m_ref = (m_ref == 211) ? 0 : m_ref + 1;
        last_row = erow;
        last_col = ecol;
        falls++;
        if (do_shift) begin
            m_row   = row;
            m_cword = cw;
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        check({rd_a, rd_b, wr_c, rfsh, row_err} == 5'b0, "R10 reset pulses", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({rd_a, rd_b, wr_c, rfsh, row_err} == 5'b0, "R10 idle pulses",
              int'({rd_a, rd_b, wr_c, rfsh, row_err}), 0);
        check(cmd_row == 0 && cmd_col == 0, "R10 reset addresses", int'(cmd_row), 0);

        // warm-up (R7): seven random words, including refresh and bad rows
        for (int i = 0; i < 7; i++)
            re_cycle(8'($urandom), 8'($urandom), 1'b1);
        // eighth word: read to latch B, row 5, column 33
        re_cycle(8'd5, {2'b01, 6'd33}, 1'b1);
        // directed corner cases
        re_cycle(8'd211, {2'b00, 6'd63}, 1'b1);  // R4 rd_a boundary row
        re_cycle(8'd212, {2'b10, 6'd7}, 1'b1);   // R8 first bad row
        re_cycle(8'd200, {2'b11, 6'd17}, 1'b1);  // R5 refresh ignores words
        re_cycle(8'd0, {2'b10, 6'd0}, 1'b1);     // R4 wr_c row 0
        re_cycle(8'd255, {2'b01, 6'd1}, 1'b1);   // R8 bad row 255
        re_cycle(8'd9, {2'b11, 6'd0}, 1'b1);     // R6 refresh after error
        re_cycle(8'hA5, {2'b01, 6'h2A}, 1'b1);   // R1 bit order pattern
        // constrained random mix
        for (int i = 0; i < 60; i++) begin
            bit [7:0] r = 8'($urandom_range(0, 230));
            re_cycle(r, 8'($urandom), 1'b1);
        end
        // R6 wrap: refresh words repeated without reshifting
        re_cycle(8'd0, {2'b11, 6'd0}, 1'b1);
        for (int i = 0; i < 216; i++)
            re_cycle(8'd0, 8'd0, 1'b0);
        re_cycle(8'd100, {2'b00, 6'd12}, 1'b1);
        re_cycle(8'd0, 8'd0, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule